// File: doc/BRIEF.md
# Indexed Configuration Register Slave on a Two-Wire Bus

This block is a serial slave on a two-wire bus (SMBus-style SCL and SDA, with SDA driven open-drain through an output enable). Behind the bus sits a bank of 32 byte-wide configuration registers. The whole bank is presented to the core in parallel as one flat vector. A host selects the bank with the write address byte D2h and sends a register offset. It then either writes a byte count followed by data bytes, or issues a repeated start with the read address byte D3h and clocks data out. In a read, the first byte the slave returns is the content of register 8, which acts as the advertised block length. The data from the offset follows it.

The register index advances after every data byte and wraps within the bank. A single-register access needs no special command. A write is a block write whose count is one. A read is a block read that the host ends after the first data byte. Some bits are fixed and cannot be written. Register 7 holds a constant identity byte. The top three bits of register 3 hold straps captured right after reset.

SCL and SDA are synchronised to the system clock with two flops each. All protocol decisions are taken on the synchronised levels.

Top module: `cfgreg_slave`

## Requirements
- R1: The slave acknowledges the address bytes D2h (write) and D3h (read). After any other address byte it gives no ACK on any later byte, and no register changes until the next start.
- R2: A block write is address D2h, offset, count N, then data bytes. The slave acknowledges all of these bytes. Data byte k is stored at index offset+k, and the new value appears on `regImage` before the stop.
- R3: A count of 0 makes every following data byte acknowledged but ignored: no register changes.
- R4: Data bytes beyond the N-th are acknowledged and discarded.
- R5: After D2h, offset, repeated start and D3h, the slave first returns register 8 and then the registers from the offset upward. A byte read is this sequence ended after the first data byte.
- R6: When the host answers a byte with NACK (SDA high on the 9th clock), the slave releases SDA and returns only ones for any further clocks until a new start.
- R7: The offset is taken modulo 32 (its low five bits). The index wraps from 31 to 0 in both reads and writes.
- R8: Register 7 reads {revision[3:0], vendor[3:0]}, which is 21h by default. Writes to it have no effect.
- R9: Bits 7:5 of register 3 hold `strapIn` as sampled on the first clock edge after reset release, and later `strapIn` changes are ignored. Bits 4:0 of register 3 are writable.
- R10: After reset, registers 0 to 2 read FFh, register 8 reads 1Fh, register 7 reads its identity byte, register 3 reads {strap, 00000b}, and all other registers read 00h.
- R11: A start seen after the second or a later bit of a byte, or a stop anywhere in a byte, aborts the transfer with no register change. The next complete transfer works normally.
- R12: `sdaOe` is high only for an ACK bit or a 0 data bit. It is low after reset, and it changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| sdaOe | output | 1 | Pull SDA low when high |
| strapIn | input | 3 | Strap levels captured into register 3 bits 7:5 after reset |
| regImage | output | 256 | All 32 registers, register i at bits 8i+7:8i |

## Verification
A wrong bit counter shows at once as an ACK pulse on the wrong SCL clock. The host sees the missing or misplaced ACK within the same byte. A wrong index or count stays hidden until the next data byte moves. It then appears either on `regImage`, one cycle after the falling SCL edge that ends that byte, or as a wrong value in the next byte read back. A faulty read-only mask or a lost strap shows on `regImage` after the first write that reaches the register. For that reason the bench writes every register and reads every register back, so that any index or mask error becomes visible at the ports.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    FR_ADDR,
    FR_OFFSET,
    FR_COUNT,
    FR_DATA
  } frame_t;

  // strobes from the protocol control to the register datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic setIndex;  // received byte is the register offset
    logic setCount;  // received byte is the write count
    logic wrData;    // received byte is a data byte
    logic loadCnt;   // load count register into the transmit shifter
    logic loadData;  // load indexed register into the transmit shifter
    logic shiftOut;  // advance the transmit shifter
  } strobe_t;

endpackage

// File: rtl/cfgreg_ctrl.sv
module cfgreg_ctrl
  import cfgreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [DW-1:0] rxByte,
  input  logic          txBit,
  output strobe_t       stb,
  output logic          sdaOe,
  output logic          sclLevel,
  output logic          sdaLevel
);
  localparam int CNT_W = $clog2(DW + 1);

  logic sclMeta, sclS, sclQ, sdaMeta, sdaS, sdaQ;
  logic sclRise, sclFall, startEv, stopEv;

  busState_t state, stNext;
  frame_t frame, frNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic readMode, rdNext, nackSeen, nkNext;

  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startEv = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv  = sclS & sclQ & ~sdaQ & sdaS;

  assign sclLevel = sclS;
  assign sdaLevel = sdaS;
  assign sdaOe = (state == ST_ACK) || (state == ST_TX && !txBit);

  always_comb begin
    stNext  = state;
    frNext  = frame;
    cntNext = bitCnt;
    rdNext  = readMode;
    nkNext  = nackSeen;
    stb     = '0;
    if (stopEv) begin
      stNext = ST_IDLE;
    end else if (startEv) begin
      // a start one bit into a frame is a repeated start, later ones abort
      if (state == ST_IDLE || state == ST_WAIT ||
          (state == ST_RX && bitCnt <= CNT_W'(1))) begin
        stNext  = ST_RX;
        frNext  = FR_ADDR;
        cntNext = '0;
      end else begin
        stNext = ST_IDLE;
      end
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt < CNT_W'(DW)) begin
            stb.shiftIn = 1'b1;
            cntNext = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_W'(DW)) begin
            stNext = ST_ACK;
            case (frame)
              FR_ADDR: begin
                if (rxByte[DW-1:1] == DEV_ADDR) begin
                  rdNext = rxByte[0];
                  frNext = FR_OFFSET;
                end else begin
                  stNext = ST_WAIT;
                end
              end
              FR_OFFSET: begin
                stb.setIndex = 1'b1;
                frNext = FR_COUNT;
              end
              FR_COUNT: begin
                stb.setCount = 1'b1;
                frNext = FR_DATA;
              end
              default: stb.wrData = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntNext = '0;
            if (readMode) begin
              stNext = ST_TX;
              stb.loadCnt = 1'b1;
            end else begin
              stNext = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == CNT_W'(DW - 1)) begin
              stNext  = ST_MACK;
              cntNext = '0;
            end else begin
              stb.shiftOut = 1'b1;
              cntNext = bitCnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) nkNext = sdaS;
          if (sclFall) begin
            if (nackSeen) begin
              stNext = ST_WAIT;
            end else begin
              stNext = ST_TX;
              stb.loadData = 1'b1;
              cntNext = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta  <= 1'b1;
      sclS     <= 1'b1;
      sclQ     <= 1'b1;
      sdaMeta  <= 1'b1;
      sdaS     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= ST_IDLE;
      frame    <= FR_ADDR;
      bitCnt   <= '0;
      readMode <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      sclMeta  <= sclIn;
      sclS     <= sclMeta;
      sclQ     <= sclS;
      sdaMeta  <= sdaIn;
      sdaS     <= sdaMeta;
      sdaQ     <= sdaS;
      state    <= stNext;
      frame    <= frNext;
      bitCnt   <= cntNext;
      readMode <= rdNext;
      nackSeen <= nkNext;
    end
  end

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DW = 8,
  parameter int CNT_REG = 8,
  parameter logic [DW-1:0] CNT_DEFAULT = 8'h1F,
  parameter int ID_REG = 7,
  parameter logic [3:0] REV_ID = 4'h2,
  parameter logic [3:0] VENDOR_ID = 4'h1,
  parameter int STRAP_REG = 3,
  parameter int STRAP_W = 3,
  parameter int EN_REGS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic                   sdaBit,
  input  logic [STRAP_W-1:0]     strapIn,
  output logic [DW-1:0]          rxByte,
  output logic                   txBit,
  output logic [NUM_REGS*DW-1:0] regImage
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int STRAP_LSB = DW - STRAP_W;

  function automatic logic [DW-1:0] defVal(input int i);
    if (i == ID_REG) return DW'({REV_ID, VENDOR_ID});
    if (i == CNT_REG) return CNT_DEFAULT;
    if (i < EN_REGS) return '1;
    return '0;
  endfunction

  function automatic logic [DW-1:0] roMask(input int i);
    if (i == ID_REG) return '1;
    if (i == STRAP_REG) return {{STRAP_W{1'b1}}, {STRAP_LSB{1'b0}}};
    return '0;
  endfunction

  logic [DW-1:0] rxSh, txSh, remain;
  logic [IDX_W-1:0] idx;
  logic strapDone, wrLive;

  assign wrLive = stb.wrData && (remain != '0);
  assign rxByte = rxSh;
  assign txBit  = txSh[DW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      txSh      <= '1;
      remain    <= '0;
      idx       <= '0;
      strapDone <= 1'b0;
    end else begin
      strapDone <= 1'b1;
      if (stb.shiftIn) rxSh <= {rxSh[DW-2:0], sdaBit};
      if (stb.setIndex) idx <= rxSh[IDX_W-1:0];
      else if (wrLive || stb.loadData) idx <= idx + 1'b1;
      if (stb.setCount) remain <= rxSh;
      else if (wrLive) remain <= remain - 1'b1;
      if (stb.loadCnt) txSh <= regImage[CNT_REG*DW +: DW];
      else if (stb.loadData) txSh <= regImage[idx*DW +: DW];
      else if (stb.shiftOut) txSh <= {txSh[DW-2:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] RO = roMask(g);
    localparam logic [DW-1:0] DEF = defVal(g);
    logic [DW-1:0] q, merged;
    logic hit;
    assign hit = wrLive && (idx == IDX_W'(g));
    assign merged = (q & RO) | (rxSh & ~RO);
    if (g == STRAP_REG) begin : g_strap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= DEF;
        else if (!strapDone) q <= {strapIn, q[STRAP_LSB-1:0]};
        else if (hit) q <= merged;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= DEF;
        else if (hit) q <= merged;
      end
    end
    assign regImage[g*DW +: DW] = q;
  end

endmodule

// File: rtl/cfgreg_slave.sv
module cfgreg_slave
  import cfgreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DW = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69,
  parameter int CNT_REG = 8,
  parameter logic [DW-1:0] CNT_DEFAULT = 8'h1F,
  parameter int ID_REG = 7,
  parameter logic [3:0] REV_ID = 4'h2,
  parameter logic [3:0] VENDOR_ID = 4'h1,
  parameter int STRAP_REG = 3,
  parameter int STRAP_W = 3,
  parameter int EN_REGS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  input  logic [STRAP_W-1:0]     strapIn,
  output logic [NUM_REGS*DW-1:0] regImage
);
  strobe_t stb;
  logic [DW-1:0] rxByte;
  logic txBit, sclLevel, sdaLevel;

  cfgreg_ctrl #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel)
  );

  cfgreg_store #(
    .NUM_REGS(NUM_REGS), .DW(DW), .CNT_REG(CNT_REG), .CNT_DEFAULT(CNT_DEFAULT),
    .ID_REG(ID_REG), .REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID),
    .STRAP_REG(STRAP_REG), .STRAP_W(STRAP_W), .EN_REGS(EN_REGS)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaLevel), .strapIn(strapIn),
    .rxByte(rxByte), .txBit(txBit), .regImage(regImage)
  );

endmodule

// File: rtl/cfgreg_slave_chk.sv
module cfgreg_slave_chk #(
  parameter int NUM_REGS = 32,
  parameter int DW = 8,
  parameter int ID_REG = 7,
  parameter logic [DW-1:0] ID_VALUE = 8'h21,
  parameter int STRAP_REG = 3,
  parameter int STRAP_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sdaOe,
  input logic                   sclLevel,
  input logic [NUM_REGS*DW-1:0] regImage
);
  logic [NUM_REGS*DW-1:0] prevImg;
  logic [1:0] age;
  logic [NUM_REGS-1:0] diff;
  logic settled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevImg <= '0;
      age     <= '0;
    end else begin
      prevImg <= regImage;
      if (age != 2'd3) age <= age + 1'b1;
    end
  end

  assign settled = (age >= 2'd2);

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      diff[i] = (regImage[i*DW +: DW] != prevImg[i*DW +: DW]);
  end

  // R2: a data byte changes at most one register
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> ($countones(diff) <= 1));

  // R11: registers change only on a completed byte, which ends on an SCL fall
  p_commit_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (settled && (diff != '0)) |-> !$past(sclLevel));

  // R8: identity register never moves
  p_id_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    regImage[ID_REG*DW +: DW] == ID_VALUE);

  // R9: strap bits hold once captured
  p_strap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> $stable(regImage[STRAP_REG*DW + DW - STRAP_W +: STRAP_W]));

  // R12: the data driver toggles only while the bus clock is low
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclLevel);

endmodule

bind cfgreg_slave cfgreg_slave_chk #(
  .NUM_REGS(NUM_REGS), .DW(DW), .ID_REG(ID_REG),
  .ID_VALUE(DW'({REV_ID, VENDOR_ID})), .STRAP_REG(STRAP_REG), .STRAP_W(STRAP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLevel(sclLevel), .regImage(regImage)
);

// File: tb/cfgreg_slave_tb.sv
module cfgreg_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] strapIn = 3'b101;
  logic sdaOe;
  logic [255:0] regImage;
  wire sdaLine = mSda & ~sdaOe;

  int nChecks = 0;
  int nFail = 0;
  int driveErr = 0;
  bit finished = 0;
  logic [7:0] mdl [32];

  always #10 clk = ~clk;

  cfgreg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapIn(strapIn), .regImage(regImage)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] roOf(input int i);
    if (i == 7) return 8'hFF;
    if (i == 3) return 8'hE0;
    return 8'h00;
  endfunction

  task automatic checkAll(input string tag);
    for (int i = 0; i < 32; i++) chk(tag, regImage[i*8 +: 8], mdl[i]);
  endtask

  task automatic busBit(input logic b, output logic seen);
    tick(Q); mSda = b; tick(Q); mScl = 1'b1; tick(Q); seen = sdaLine; tick(Q); mScl = 1'b0;
  endtask

  task automatic startCond();
    tick(Q); mSda = 1'b1; tick(Q); mScl = 1'b1; tick(Q); mSda = 1'b0; tick(Q); mScl = 1'b0;
  endtask

  task automatic stopCond();
    tick(Q); mSda = 1'b0; tick(Q); mScl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackd);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(v[i], s);
      if (s !== v[i]) driveErr++;
    end
    busBit(1'b1, s);
    ackd = !s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, s);
      v[i] = s;
    end
    busBit(!ackIt, s);
  endtask

  task automatic blockWrite(input logic [7:0] addrByte, input logic [7:0] off,
                            input logic [7:0] cnt, input int nData,
                            input logic [7:0] seed, output int acks);
    logic a;
    logic [7:0] v;
    int ix;
    acks = 0;
    startCond();
    sendByte(addrByte, a); acks += int'(a);
    sendByte(off, a); acks += int'(a);
    sendByte(cnt, a); acks += int'(a);
    for (int k = 0; k < nData; k++) begin
      v = seed + 8'(k * 29);
      sendByte(v, a); acks += int'(a);
      if (addrByte == 8'hD2 && k < int'(cnt)) begin
        ix = (int'(off) + k) % 32;
        mdl[ix] = (mdl[ix] & roOf(ix)) | (v & ~roOf(ix));
      end
    end
    stopCond();
  endtask

  task automatic blockRead(input logic [7:0] off, input int nData, input string tag);
    logic a;
    logic [7:0] v;
    int ix;
    startCond();
    sendByte(8'hD2, a); chk({tag, " write address ack R1"}, a, 1);
    sendByte(off, a);   chk({tag, " offset ack R2"}, a, 1);
    startCond();
    sendByte(8'hD3, a); chk({tag, " read address ack R1"}, a, 1);
    recvByte(nData > 0, v);
    chk({tag, " count byte R5"}, v, mdl[8]);
    ix = int'(off) % 32;
    for (int k = 0; k < nData; k++) begin
      recvByte(k != nData - 1, v);
      chk({tag, " data R5 R7"}, v, mdl[ix]);
      ix = (ix + 1) % 32;
    end
    stopCond();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    summary();
  end

  initial begin
    int acks;
    logic a;
    logic [7:0] v;
    for (int i = 0; i < 32; i++)
      mdl[i] = (i < 3) ? 8'hFF : (i == 8) ? 8'h1F : (i == 7) ? 8'h21 : 8'h00;
    mdl[3] = {3'b101, 5'b0};
    tick(5);
    rstN = 1'b1;
    tick(3);
    strapIn = 3'b010;
    tick(4);
    chk("reset sdaOe low R12", sdaOe, 0);
    checkAll("reset defaults R10");
    chk("strap captured R9", regImage[3*8+5 +: 3], 3'b101);

    // full sweep write of the bank
    blockWrite(8'hD2, 8'd0, 8'd32, 32, 8'd5, acks);
    chk("sweep write acks R2", acks, 35);
    checkAll("sweep write R2 R8 R9");

    // full read from offset 5, wrapping through the bank
    blockRead(8'd5, 32, "wrap read R7");

    // one-byte writes then one-byte reads at every index
    for (int i = 0; i < 32; i++) begin
      blockWrite(8'hD2, 8'(i), 8'd1, 1, 8'(i) ^ 8'hA5, acks);
      chk("byte write acks R2", acks, 4);
    end
    checkAll("byte writes R2 R8 R9");
    for (int i = 0; i < 32; i++) blockRead(8'(i), 1, "byte read R5");

    // foreign address
    blockWrite(8'hA0, 8'd4, 8'd1, 1, 8'h3C, acks);
    chk("foreign address acks R1", acks, 0);
    checkAll("foreign address R1");

    // count zero
    blockWrite(8'hD2, 8'd10, 8'd0, 2, 8'h77, acks);
    chk("zero count acks R3", acks, 5);
    checkAll("zero count R3");

    // bytes beyond count
    blockWrite(8'hD2, 8'd30, 8'd1, 3, 8'h11, acks);
    chk("over count acks R4", acks, 6);
    checkAll("over count R4");

    // wrap on write, and offset above 31
    blockWrite(8'hD2, 8'd31, 8'd2, 2, 8'h9A, acks);
    chk("wrap write R7", regImage[0 +: 8], mdl[0]);
    blockWrite(8'hD2, 8'h45, 8'd1, 1, 8'hC3, acks);
    chk("offset modulo R7", regImage[5*8 +: 8], 8'hC3);
    checkAll("index handling R7");

    // read-only fields
    blockWrite(8'hD2, 8'd7, 8'd1, 1, 8'h00, acks);
    chk("identity write ignored R8", regImage[7*8 +: 8], 8'h21);
    blockWrite(8'hD2, 8'd3, 8'd1, 1, 8'hFF, acks);
    chk("strap bits kept R9", regImage[3*8 +: 8], 8'hBF);

    // NACK then further clocks return ones
    startCond();
    sendByte(8'hD2, a);
    sendByte(8'd2, a);
    startCond();
    sendByte(8'hD3, a);
    recvByte(1'b1, v);
    recvByte(1'b0, v);
    chk("nacked byte data R5", v, mdl[2]);
    recvByte(1'b1, v);
    chk("released after nack R6", v, 8'hFF);
    stopCond();

    // start in the middle of a data byte
    startCond();
    sendByte(8'hD2, a);
    sendByte(8'd12, a);
    sendByte(8'd1, a);
    for (int i = 0; i < 4; i++) busBit(1'b0, a);
    startCond();
    stopCond();
    checkAll("mid-byte start abort R11");
    // stop in the middle of a data byte
    startCond();
    sendByte(8'hD2, a);
    sendByte(8'd13, a);
    sendByte(8'd1, a);
    for (int i = 0; i < 5; i++) busBit(1'b0, a);
    stopCond();
    checkAll("mid-byte stop abort R11");
    blockWrite(8'hD2, 8'd12, 8'd1, 1, 8'h5E, acks);
    chk("transfer after abort R11", regImage[12*8 +: 8], 8'h5E);

    tick(10);
    chk("slave never drove during host bits R12", driveErr, 0);
    chk("idle sdaOe low R12", sdaOe, 0);
    summary();
  end

endmodule